// File: doc/BRIEF.md
# I2C master byte transmitter

This block is the transmit half of an I2C bus master, limited to writes to a slave with a 7-bit address. Software works it through a one-byte holding register and a few command strobes. The first byte written is the slave address in bits 7:1 with a 0 write bit in bit 0. A start command then issues a START condition and moves the held byte into a shift register. Bits go out most significant first, with SCL made by a fixed half-period counter.

The holding register is reported empty as soon as the first bit of the byte being shifted has been clocked out. Software can therefore queue the next byte while the current one is still on the bus. The slave's answer is sampled at the end of the high half of the ninth clock, and the result is latched in three status bits.

On an acknowledge with a byte queued, the next byte follows without a gap. On an acknowledge with nothing queued, SCL is held low. On a not-acknowledge, the engine parks with SCL low until software requests STOP. STOP throws away any queued byte and finishes with a STOP condition. Both bus lines are open-drain: an output enable pulls the line low, and SDA is read back through a synchronizer.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset the engine is idle. Both line enables are off, the empty flag is 1, and the ack-valid, ack, not-ack and both interrupt outputs are 0 while the transmit-interrupt enable is 0.
- R2: When a start command arrives with a byte held, the next clock edge pulls SDA low while SCL stays released (START), and `busy` rises on that edge.
- R3: Every byte goes out MSB first, and the first byte of a transfer is {address[6:0], 0}. SDA changes only while SCL is low, except for the START and STOP edges, so a listener sees exactly one START and one STOP per transfer. Each SCL half-period lasts HALF clocks.
- R4: `flag_tdre` (1 = holding register empty) rises 4*HALF clock edges after the edge that samples the start command, which is the end of the first address bit. `irq_tx` equals `flag_tdre` when `txi_en` is 1 and is 0 when `txi_en` is 0.
- R5: The slave's answer is sampled at the end of the ninth clock's high half. For the address byte, `flag_ackv` rises 20*HALF edges after the start edge. An ack (SDA low) sets `flag_ack`=1 and `flag_ackv`=1.
- R6: A not-acknowledge (SDA high) sets `flag_nack`=1, `flag_ackv`=1 and `flag_ack`=0, raises `irq_nack`, and keeps SCL pulled low until STOP is requested.
- R7: A STOP request after a not-acknowledge discards any queued byte (`flag_tdre` reads 1 afterwards), drives a STOP condition and clears `flag_nack`. No further byte reaches the bus.
- R8: When a byte is acknowledged and another byte is already queued, the queued byte is shifted next. Multi-byte transfers deliver every byte in write order.
- R9: When a byte is acknowledged, no byte is queued and no STOP is requested, SCL stays low and `busy` stays 1 until a byte is written. The transfer then resumes.
- R10: A STOP request after an acknowledge ends the transfer with SDA rising while SCL is high. `busy` then falls with both line enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_wr | input | 1 | Write strobe for the holding register |
| dat_in | input | DW | Byte to hold |
| go_start | input | 1 | Start command strobe |
| go_stop | input | 1 | Stop request strobe |
| txi_en | input | 1 | Transmit interrupt enable |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |
| busy | output | 1 | Transfer in progress |
| flag_tdre | output | 1 | Holding register empty |
| flag_ackv | output | 1 | Acknowledge result valid |
| flag_ack | output | 1 | Last byte acknowledged |
| flag_nack | output | 1 | Last byte not acknowledged |
| irq_tx | output | 1 | Transmit interrupt |
| irq_nack | output | 1 | Not-acknowledge interrupt |

## Verification
START is due on the first clock edge after the start strobe is sampled. The empty flag is due 4*HALF edges after that edge, and the first ack result 20*HALF edges after it. Every later ack result follows 18*HALF edges after the byte is loaded.

The bench drives inputs and samples outputs on falling clock edges. It counts rising edges from the sampling edge of the start strobe and compares the counts against these figures. Bus-level results (bytes delivered, START and STOP counts) are collected by a slave model that watches the lines every clock. They are checked only after `busy` has fallen.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [3:0] {
      S_IDLE,
      S_STA,
      S_STB,
      S_BITL,
      S_BITH,
      S_ACKL,
      S_ACKH,
      S_HOLD,
      S_SPA,
      S_SPB,
      S_SPC
   } i2cm_state_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int HALF = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   assign done = (cnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || done) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/i2cm_shift.sv
module i2cm_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [DW-1:0] din,
   output logic          msb,
   output logic          first,
   output logic          last
);
   localparam int BW = (DW > 1) ? $clog2(DW) : 1;

   logic [DW-1:0] sr;
   logic [BW-1:0] bit_idx;

   assign msb   = sr[DW-1];
   assign first = (bit_idx == '0);
   assign last  = (bit_idx == BW'(DW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         bit_idx <= '0;
      end else if (load) begin
         sr      <= din;
         bit_idx <= '0;
      end else if (adv) begin
         sr      <= {sr[DW-2:0], 1'b0};
         bit_idx <= bit_idx + BW'(1);
      end
   end
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  r[i] <= r[i-1];
               end
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_master_tx.sv
module i2c_master_tx #(
   parameter int HALF        = 125,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dat_wr,
   input  logic [DW-1:0] dat_in,
   input  logic          go_start,
   input  logic          go_stop,
   input  logic          txi_en,
   output logic          scl_oe,
   output logic          sda_oe,
   input  logic          sda_in,
   output logic          busy,
   output logic          flag_tdre,
   output logic          flag_ackv,
   output logic          flag_ack,
   output logic          flag_nack,
   output logic          irq_tx,
   output logic          irq_nack
);
   import i2cm_pkg::*;

   generate
      if (HALF < 2) begin : g_bad_half
         $error("HALF must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   i2cm_state_e   state;
   logic [DW-1:0] hold_q;
   logic          full;
   logic          reveal;
   logic          start_req;
   logic          stop_req;
   logic          ackv_q;
   logic          ack_q;
   logic          nack_q;

   logic done, tick_clr, sda_s;
   logic sh_msb, sh_first, sh_last;
   logic stop_eff, load, adv;

   assign tick_clr = (state == S_IDLE) || (state == S_HOLD);
   assign stop_eff = stop_req || go_stop;

   assign load = ((state == S_STB) && done)
              || ((state == S_ACKH) && done && !sda_s && !stop_eff && full)
              || ((state == S_HOLD) && !nack_q && !stop_eff && full);
   assign adv  = (state == S_BITH) && done && !sh_last;

   i2cm_tick #(.HALF(HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .done  (done)
   );

   i2cm_shift #(.DW(DW)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .adv   (adv),
      .din   (hold_q),
      .msb   (sh_msb),
      .first (sh_first),
      .last  (sh_last)
   );

   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         hold_q    <= '0;
         full      <= 1'b0;
         reveal    <= 1'b1;
         start_req <= 1'b0;
         stop_req  <= 1'b0;
         ackv_q    <= 1'b0;
         ack_q     <= 1'b0;
         nack_q    <= 1'b0;
      end else begin
         if (go_start) start_req <= 1'b1;
         if (go_stop && state != S_IDLE) stop_req <= 1'b1;
         if (load) begin
            full   <= 1'b0;
            reveal <= 1'b0;
         end
         case (state)
            S_IDLE: if ((start_req || go_start) && full) state <= S_STA;
            S_STA:  if (done) state <= S_STB;
            S_STB:  if (done) state <= S_BITL;
            S_BITL: if (done) state <= S_BITH;
            S_BITH: if (done) begin
               if (sh_first) begin
                  reveal <= 1'b1;
                  ackv_q <= 1'b0;
               end
               state <= sh_last ? S_ACKL : S_BITL;
            end
            S_ACKL: if (done) state <= S_ACKH;
            S_ACKH: if (done) begin
               ackv_q <= 1'b1;
               ack_q  <= !sda_s;
               nack_q <= sda_s;
               if (sda_s) begin
                  state <= S_HOLD;
               end else if (stop_eff) begin
                  full  <= 1'b0;
                  state <= S_SPA;
               end else if (full) begin
                  state <= S_BITL;
               end else begin
                  state <= S_HOLD;
               end
            end
            S_HOLD: begin
               if (stop_eff) begin
                  full  <= 1'b0;
                  state <= S_SPA;
               end else if (!nack_q && full) begin
                  state <= S_BITL;
               end
            end
            S_SPA: if (done) state <= S_SPB;
            S_SPB: if (done) state <= S_SPC;
            S_SPC: if (done) begin
               state     <= S_IDLE;
               start_req <= 1'b0;
               stop_req  <= 1'b0;
               nack_q    <= 1'b0;
            end
            default: state <= S_IDLE;
         endcase
         if (dat_wr) begin
            hold_q <= dat_in;
            full   <= 1'b1;
         end
      end
   end

   always_comb begin
      scl_oe = (state == S_STB) || (state == S_BITL) || (state == S_ACKL)
            || (state == S_HOLD) || (state == S_SPA);
      case (state)
         S_STA, S_STB, S_SPA, S_SPB: sda_oe = 1'b1;
         S_BITL, S_BITH:             sda_oe = !sh_msb;
         default:                    sda_oe = 1'b0;
      endcase
   end

   assign busy      = (state != S_IDLE);
   assign flag_tdre = reveal && !full;
   assign flag_ackv = ackv_q;
   assign flag_ack  = ack_q;
   assign flag_nack = nack_q;
   assign irq_tx    = txi_en && flag_tdre;
   assign irq_nack  = nack_q;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic scl_oe,
   input logic sda_oe,
   input logic flag_ack,
   input logic flag_ackv,
   input logic flag_nack,
   input logic in_bith
);
   // R2: START is SDA low with SCL released when a transfer begins
   a_r2_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (sda_oe && !scl_oe));

   // R3: data line steady through the high half of a bit
   a_r3_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bith && $past(in_bith)) |-> $stable(sda_oe));

   // R6: not-ack status combination
   a_r6_nack_flags: assert property (@(posedge clk) disable iff (!rst_n)
      flag_nack |-> (flag_ackv && !flag_ack));

   // R6: clock pulled low once a not-ack is seen
   a_r6_nack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_nack) |-> scl_oe);

   // R7 and R10: transfer ends with both lines released and not-ack cleared
   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!scl_oe && !sda_oe && !flag_nack));
endmodule

bind i2c_master_tx i2cm_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .flag_ack  (flag_ack),
   .flag_ackv (flag_ackv),
   .flag_nack (flag_nack),
   .in_bith   (state == i2cm_pkg::S_BITH)
);

// File: tb/i2c_master_tx_tb.sv
`timescale 1ns/1ps
module i2c_master_tx_tb;
   localparam int H = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dat_wr = 1'b0;
   logic [7:0] dat_in = '0;
   logic go_start = 1'b0, go_stop = 1'b0, txi_en = 1'b0;
   logic scl_oe, sda_oe, sda_in, busy;
   logic flag_tdre, flag_ackv, flag_ack, flag_nack, irq_tx, irq_nack;

   always #2.5 clk = ~clk;

   logic slv_low;
   logic scl_line, sda_line;
   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | slv_low);
   assign sda_in   = sda_line;

   i2c_master_tx #(.HALF(H), .DW(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_in(dat_in),
      .go_start(go_start), .go_stop(go_stop), .txi_en(txi_en),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in), .busy(busy),
      .flag_tdre(flag_tdre), .flag_ackv(flag_ackv), .flag_ack(flag_ack),
      .flag_nack(flag_nack), .irq_tx(irq_tx), .irq_nack(irq_nack));

   // slave model
   logic [3:0] mask;
   logic scl_p, sda_p;
   int   bitc, bidx, n_start, n_stop, rx_tot;
   logic [7:0] sh;
   logic [7:0] rxlog [64];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1; sda_p <= 1'b1; slv_low <= 1'b0;
         bitc <= 0; bidx <= 0; n_start <= 0; n_stop <= 0; rx_tot <= 0; sh <= '0;
      end else begin
         scl_p <= scl_line;
         sda_p <= sda_line;
         if (scl_line && scl_p && sda_p && !sda_line) begin
            n_start <= n_start + 1; bitc <= 0; bidx <= 0;
         end else if (scl_line && scl_p && !sda_p && sda_line) begin
            n_stop <= n_stop + 1;
         end else if (scl_line && !scl_p) begin
            if (bitc < 8) sh <= {sh[6:0], sda_line};
            if (bitc == 7) begin
               rxlog[rx_tot[5:0]] <= {sh[6:0], sda_line};
               rx_tot <= rx_tot + 1;
            end
            bitc <= bitc + 1;
         end else if (!scl_line && scl_p) begin
            if (bitc == 8) slv_low <= (bidx < 4) ? mask[bidx[1:0]] : 1'b1;
            else if (bitc == 9) begin slv_low <= 1'b0; bitc <= 0; bidx <= bidx + 1; end
         end
      end
   end

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic [7:0] b);
      dat_in = b; dat_wr = 1'b1;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic pulse_start();
      go_start = 1'b1; @(negedge clk); go_start = 1'b0;
   endtask

   task automatic pulse_stop();
      go_stop = 1'b1; @(negedge clk); go_stop = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int t = 0;
      while (busy && t < 2000) begin @(negedge clk); t++; end
      chk(!busy, req, busy, 0);
   endtask

   typedef struct packed {
      logic [6:0] a;
      logic [1:0] n;
      logic [7:0] d0, d1, d2;
      logic [3:0] m;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{7'h50, 2'd2, 8'hA5, 8'h3C, 8'h00, 4'b1111},
      '{7'h2A, 2'd3, 8'h01, 8'hFF, 8'h80, 4'b1111},
      '{7'h11, 2'd1, 8'h5A, 8'h00, 8'h00, 4'b1110},
      '{7'h7F, 2'd3, 8'h00, 8'hC3, 8'hE7, 4'b1011},
      '{7'h00, 2'd1, 8'h96, 8'h00, 8'h00, 4'b0011}
   };

   function automatic logic [7:0] vbyte(input vec_t v, input int i);
      case (i)
         0: return {v.a, 1'b0};
         1: return v.d0;
         2: return v.d1;
         default: return v.d2;
      endcase
   endfunction

   task automatic run_vec(input vec_t v);
      int base_rx, base_st, base_sp, sent, acks, expn, t;
      bit prev, fin, nacked;
      base_rx = rx_tot; base_st = n_start; base_sp = n_stop;
      mask = v.m;
      expn = int'(v.n) + 1;
      for (int i = 0; i <= int'(v.n); i++) begin
         if (!v.m[i]) begin expn = i + 1; break; end
      end
      wr_byte(vbyte(v, 0));
      pulse_start();
      sent = 0; acks = 0; prev = flag_ackv; fin = 0; nacked = 0; t = 0;
      while (!fin && t < 5000) begin
         if (flag_tdre && sent < int'(v.n)) begin
            chk(irq_tx == 1'b1, "R4 irq_tx with txi_en", irq_tx, 1);
            wr_byte(vbyte(v, sent + 1)); sent++;
            prev = flag_ackv;
         end else begin
            if (flag_ackv && !prev) begin
               if (flag_nack) begin
                  chk(!flag_ack && irq_nack && scl_line == 1'b0, "R6 nack flags",
                      {flag_ack, irq_nack, scl_line}, 3'b010);
                  if (sent > acks) chk(!flag_tdre, "R7 byte pending before flush", flag_tdre, 0);
                  nacked = 1;
                  pulse_stop(); fin = 1;
               end else begin
                  acks++;
                  if (acks == int'(v.n) + 1) begin
                     chk(flag_ack, "R5 ack flag", flag_ack, 1);
                     pulse_stop(); fin = 1;
                  end
               end
            end
            prev = flag_ackv;
            if (!fin) begin @(negedge clk); t++; end
         end
      end
      chk(fin, "R8 transfer progressed", fin, 1);
      wait_idle(nacked ? "R7 stop after nack" : "R10 stop after ack");
      chk(rx_tot - base_rx == expn, "R8 byte count", rx_tot - base_rx, expn);
      for (int i = 0; i < expn; i++) begin
         chk(rxlog[(base_rx + i) % 64] == vbyte(v, i), "R3 byte value MSB first",
             rxlog[(base_rx + i) % 64], vbyte(v, i));
      end
      chk(n_start - base_st == 1, "R3 one START", n_start - base_st, 1);
      chk(n_stop - base_sp == 1, "R10 one STOP", n_stop - base_sp, 1);
      chk(!flag_nack && flag_tdre, "R7 nack cleared and queue flushed",
          {flag_nack, flag_tdre}, 2'b01);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, t;
      bit sclbad;
      mask = 4'b1111;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy, "R1 idle", busy, 0);
      chk(scl_line && sda_line, "R1 lines released", {scl_line, sda_line}, 2'b11);
      chk(flag_tdre, "R1 empty flag", flag_tdre, 1);
      chk({flag_ackv, flag_ack, flag_nack, irq_tx, irq_nack} == 5'b0, "R1 status clear",
          {flag_ackv, flag_ack, flag_nack, irq_tx, irq_nack}, 0);

      // timing, START, interrupt enable, and hold with empty register
      txi_en = 1'b1;
      wr_byte({7'h33, 1'b0});
      go_start = 1'b1;
      @(posedge clk);
      @(negedge clk); go_start = 1'b0;
      chk(sda_line == 1'b0 && scl_line == 1'b1 && busy, "R2 START one edge after command",
          {sda_line, scl_line, busy}, 3'b011);
      n = 0;
      while (!flag_tdre && n < 1000) begin @(negedge clk); n++; end
      chk(n == 4 * H, "R4 empty flag timing", n, 4 * H);
      chk(irq_tx, "R4 irq_tx follows empty flag", irq_tx, 1);
      txi_en = 1'b0;
      #1;
      chk(!irq_tx, "R4 irq_tx masked", irq_tx, 0);
      while (!flag_ackv && n < 1000) begin @(negedge clk); n++; end
      chk(n == 20 * H, "R5 ack valid timing", n, 20 * H);
      chk(flag_ack && !flag_nack, "R5 address acked", {flag_ack, flag_nack}, 2'b10);
      sclbad = 0;
      for (int i = 0; i < 10 * H; i++) begin
         @(negedge clk);
         if (scl_line || !busy) sclbad = 1;
      end
      chk(!sclbad, "R9 SCL held low while empty", sclbad, 0);
      wr_byte(8'h4E);
      t = 0;
      while (!flag_tdre && t < 1000) begin @(negedge clk); t++; end
      while (flag_ackv && t < 1000) begin @(negedge clk); t++; end
      while (!flag_ackv && t < 2000) begin @(negedge clk); t++; end
      chk(flag_ack, "R9 resumed byte acked", flag_ack, 1);
      pulse_stop();
      wait_idle("R10 stop after hold");
      chk(rxlog[(rx_tot - 1) % 64] == 8'h4E, "R9 resumed byte delivered",
          rxlog[(rx_tot - 1) % 64], 8'h4E);
      chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);

      // table-driven transfers
      txi_en = 1'b1;
      foreach (VEC[i]) begin
         run_vec(VEC[i]);
         repeat (2 * H) @(negedge clk);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule